// File: doc/BRIEF.md
# GPIO Bank Interrupt Detector

This block watches a bank of general-purpose input pins and turns level or edge activity on each of them into a sticky per-pin status flag. Every pin owns an eight-bit setup word and a one-bit status word, both reached through a small synchronous register port. Each setup word holds an interrupt enable, a status-capture enable, a polarity bit, a detection mode and a three-bit routing code. The pin inputs pass through a synchronizer chain before any edge or level test is made.

A single registered summary interrupt is raised when any pin has its status set, its interrupt enable on, and its routing code equal to the code reserved for the application processor. Because capture and enable are separate bits, a pin can record events while it is masked. Software acknowledges an event by writing the status word. A build parameter picks which written value clears it. A second build parameter picks a narrower detection field, in which one bit chooses level or edge and the polarity bit chooses the edge direction.

Top module: `gpio_irq_top`

## Requirements
- R1: After synchronous reset every setup word reads 0, every status bit reads 0 and `irq_out` is 0.
- R2: Address `{pin,0}` holds the setup word and address `{pin,1}` holds the status word in bit 0. Setup bits: [0] interrupt enable, [1] capture enable, [2] polarity, [4:3] detection mode, [7:5] routing code. `host_rdata` returns the addressed word one clock after the address is presented.
- R3: With the two-bit mode field, mode 0 is level (polarity 1 = active high, 0 = active low), mode 1 is rising edge, mode 2 is falling edge and mode 3 is both edges. In the edge modes polarity has no effect.
- R4: A status bit sets only while the pin's capture enable is 1, whatever its interrupt enable. It then stays set until it is acknowledged.
- R5: `irq_out` is 1 exactly when some pin has status 1, interrupt enable 1 and routing code equal to `TARGET_CODE` (default 4). Pins with another code or with the enable off never raise it.
- R6: With `ACK_HIGH`=1, writing 1 to status bit 0 clears it and writing 0 leaves it unchanged. With `ACK_HIGH`=0, writing 0 clears it and writing 1 leaves it unchanged. No write can set a status bit.
- R7: A detected event in the same cycle as an acknowledge wins, and the status stays 1. A level that is still active therefore keeps its status set through an acknowledge.
- R8: Rewriting a pin's detection mode or polarity while its input is steady sets no status unless the new setting is a level mode whose level is active. Edges are found by comparing the synchronized input with its value from the previous cycle.
- R9: With `DET_WIDTH`=1, setup bit 3 selects level (0) or edge (1). In edge mode polarity 1 means rising and 0 means falling, and bit 4 has no effect.
- R10: A change on `pin_in` is reflected in the status three clocks later (two synchronizer stages plus the status register). It reaches `irq_out` one clock after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NPINS | Asynchronous pin inputs |
| host_we | input | 1 | Register write strobe |
| host_addr | input | $clog2(NPINS)+1 | Register address, {pin, word select} |
| host_wdata | input | 8 | Register write data |
| host_rdata | output | 8 | Registered read data for the address of the previous cycle |
| irq_out | output | 1 | Registered summary interrupt |

## Verification
A pin edge driven just after a falling clock edge appears in the status on the third rising edge and on `irq_out` on the fourth. The bench therefore waits four clocks after every pin change before it queues a check. Read data and the summary are compared at the falling edge that follows the rising edge on which they were captured, so each queued expectation covers exactly one register stage. The event-versus-acknowledge race is staged by placing the acknowledge write on the third rising edge after a pin change, which is the edge on which the event is latched.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int CFG_W = 8;

  typedef struct packed {
    logic [2:0] target;
    logic [1:0] detect;
    logic       pol;
    logic       raw_en;
    logic       irq_en;
  } pin_cfg_t;

  typedef enum logic [1:0] {
    DET_LEVEL = 2'd0,
    DET_RISE  = 2'd1,
    DET_FALL  = 2'd2,
    DET_BOTH  = 2'd3
  } det_mode_e;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) chain[k] <= '0;
    end else begin
      chain[0] <= d;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
  import gpio_irq_pkg::*;
#(
  parameter int DET_WIDTH = 2,
  parameter bit ACK_HIGH  = 1'b1
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     pin_s,
  input  logic     cfg_we,
  input  pin_cfg_t cfg_wdata,
  input  logic     st_we,
  input  logic     st_wbit,
  output pin_cfg_t cfg,
  output logic     status
);

  pin_cfg_t cfg_q;
  logic     prev_q;
  logic     status_q;
  logic     rise, fall, level_hit, event_hit, ack;

  assign rise      = pin_s & ~prev_q;
  assign fall      = ~pin_s & prev_q;
  assign level_hit = (pin_s == cfg_q.pol);

  generate
    if (DET_WIDTH == 2) begin : g_det2
      always_comb begin
        case (det_mode_e'(cfg_q.detect))
          DET_LEVEL: event_hit = level_hit;
          DET_RISE:  event_hit = rise;
          DET_FALL:  event_hit = fall;
          default:   event_hit = rise | fall;
        endcase
      end
    end else begin : g_det1
      always_comb begin
        if (cfg_q.detect[0]) event_hit = cfg_q.pol ? rise : fall;
        else                 event_hit = level_hit;
      end
    end
  endgenerate

  assign ack = st_we && (st_wbit == ACK_HIGH);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q    <= '0;
      prev_q   <= 1'b0;
      status_q <= 1'b0;
    end else begin
      prev_q <= pin_s;
      if (cfg_we) cfg_q <= cfg_wdata;
      if (event_hit && cfg_q.raw_en) status_q <= 1'b1;
      else if (ack)                  status_q <= 1'b0;
    end
  end

  assign cfg    = cfg_q;
  assign status = status_q;

endmodule

// File: rtl/gpio_irq_top.sv
module gpio_irq_top
  import gpio_irq_pkg::*;
#(
  parameter int         NPINS       = 8,
  parameter int         DET_WIDTH   = 2,
  parameter bit         ACK_HIGH    = 1'b1,
  parameter int         SYNC_STAGES = 2,
  parameter logic [2:0] TARGET_CODE = 3'd4,
  localparam int        PIN_AW      = (NPINS > 1) ? $clog2(NPINS) : 1,
  localparam int        AW          = PIN_AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPINS-1:0]  pin_in,
  input  logic              host_we,
  input  logic [AW-1:0]     host_addr,
  input  logic [CFG_W-1:0]  host_wdata,
  output logic [CFG_W-1:0]  host_rdata,
  output logic              irq_out
);

  logic [NPINS-1:0]  pin_s;
  logic [NPINS-1:0]  status_vec;
  logic [NPINS-1:0]  en_vec;
  logic [NPINS-1:0]  raw_vec;
  logic [NPINS-1:0]  route_vec;
  pin_cfg_t          cfg_arr [NPINS];
  logic [PIN_AW-1:0] sel_pin;
  logic              is_status;
  logic [CFG_W-1:0]  rdata_q;
  logic              irq_q;

  assign sel_pin   = host_addr[AW-1:1];
  assign is_status = host_addr[0];

  gpio_irq_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_s)
  );

  generate
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
      logic hit_sel;
      assign hit_sel = (sel_pin == PIN_AW'(i));

      gpio_irq_pin #(.DET_WIDTH(DET_WIDTH), .ACK_HIGH(ACK_HIGH)) u_pin (
        .clk       (clk),
        .rst       (rst),
        .pin_s     (pin_s[i]),
        .cfg_we    (host_we && !is_status && hit_sel),
        .cfg_wdata (pin_cfg_t'(host_wdata)),
        .st_we     (host_we && is_status && hit_sel),
        .st_wbit   (host_wdata[0]),
        .cfg       (cfg_arr[i]),
        .status    (status_vec[i])
      );

      assign en_vec[i]    = cfg_arr[i].irq_en;
      assign raw_vec[i]   = cfg_arr[i].raw_en;
      assign route_vec[i] = (cfg_arr[i].target == TARGET_CODE);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (is_status) rdata_q <= {{(CFG_W-1){1'b0}}, status_vec[sel_pin]};
      else           rdata_q <= cfg_arr[sel_pin];
      irq_q <= |(status_vec & en_vec & route_vec);
    end
  end

  assign host_rdata = rdata_q;
  assign irq_out    = irq_q;

endmodule

// File: rtl/gpio_irq_top_chk.sv
module gpio_irq_top_chk #(
  parameter int NPINS = 8,
  parameter int AW    = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             host_we,
  input logic [AW-1:0]    host_addr,
  input logic [NPINS-1:0] status_vec,
  input logic [NPINS-1:0] en_vec,
  input logic [NPINS-1:0] raw_vec,
  input logic [NPINS-1:0] route_vec,
  input logic             irq_out
);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (status_vec == '0 && !irq_out));

  p_irq_source_r5: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(|(status_vec & en_vec & route_vec)));

  p_irq_masked_r5: assert property (@(posedge clk) disable iff (rst)
    ((status_vec & en_vec & route_vec) == '0) |=> !irq_out);

  generate
    for (genvar i = 0; i < NPINS; i++) begin : g_pin_chk
      localparam logic [AW-1:0] ST_ADDR = AW'(2 * i + 1);

      p_capture_gate_r4: assert property (@(posedge clk) disable iff (rst)
        (!status_vec[i] && !raw_vec[i]) |=> !status_vec[i]);

      p_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (status_vec[i] && !(host_we && host_addr == ST_ADDR)) |=> status_vec[i]);
    end
  endgenerate

endmodule

bind gpio_irq_top gpio_irq_top_chk #(.NPINS(NPINS), .AW(AW)) u_chk (.*);

// File: tb/gpio_irq_top_test.sv
`timescale 1ns/1ps
module gpio_irq_top_test;

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pins = '0;
  logic       we0 = 1'b0;
  logic       we1 = 1'b0;
  logic [3:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] rdata0, rdata1;
  logic       irq0, irq1;

  int    vectors = 0;
  int    miscompares = 0;
  bit    done = 1'b0;
  bit    mon_req = 1'b0;
  bit    chk_pending = 1'b0;
  item_t sb_q[$];
  item_t cur;
  logic [7:0] act;

  always #5 clk = ~clk;

  gpio_irq_top uut (
    .clk(clk), .rst(rst), .pin_in(pins), .host_we(we0), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(rdata0), .irq_out(irq0)
  );

  gpio_irq_top #(.DET_WIDTH(1), .ACK_HIGH(1'b0)) uut_n (
    .clk(clk), .rst(rst), .pin_in(pins), .host_we(we1), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(rdata1), .irq_out(irq1)
  );

  // Monitor: compares queued expectations one clock after issue.
  always @(posedge clk) chk_pending <= mon_req;

  always @(negedge clk) begin
    if (chk_pending && sb_q.size() > 0) begin
      cur = sb_q.pop_front();
      case (cur.kind)
        0: act = rdata0;
        1: act = {7'b0, irq0};
        2: act = rdata1;
        default: act = {7'b0, irq1};
      endcase
      vectors++;
      if (act !== cur.exp) begin
        miscompares++;
        $display("FAIL %s actual=%0h expected=%0h", cur.tag, act, cur.exp);
      end
    end
  end

  function automatic logic [3:0] ca(int p); return 4'(2 * p); endfunction
  function automatic logic [3:0] sa(int p); return 4'(2 * p + 1); endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int u, input logic [3:0] a, input logic [7:0] d);
    host_addr  = a;
    host_wdata = d;
    if (u == 0) we0 = 1'b1; else we1 = 1'b1;
    @(negedge clk);
    we0 = 1'b0;
    we1 = 1'b0;
  endtask

  // Driver: pushes an expectation and requests one comparison.
  task automatic chk(input int kind, input logic [3:0] a, input logic [7:0] e, input string tag);
    host_addr = a;
    sb_q.push_back('{kind, e, tag});
    mon_req = 1'b1;
    @(negedge clk);
    mon_req = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      miscompares++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    chk(0, ca(0), 8'h00, "R1 setup word after reset");
    chk(0, sa(0), 8'h00, "R1 status after reset");
    chk(1, 4'h0, 8'h00, "R1 irq after reset");

    // R2 layout / readback, R3 rising, R10 latency
    wr(0, ca(0), 8'd143);
    chk(0, ca(0), 8'd143, "R2 setup readback pin0");
    idle(2);
    chk(0, sa(0), 8'h00, "R3 no event without edge");
    pins[0] = 1'b1;
    idle(2);
    chk(0, sa(0), 8'h00, "R10 status not yet set after two clocks");
    chk(0, sa(0), 8'h01, "R10 status set on third clock");
    chk(1, 4'h0, 8'h01, "R5 irq for routed enabled pin");
    // R6 acknowledge polarity (write 1 clears)
    wr(0, sa(0), 8'h01);
    chk(0, sa(0), 8'h00, "R6 write-one clears");
    chk(1, 4'h0, 8'h00, "R5 irq drops after clear");
    pins[0] = 1'b0;
    idle(4);
    chk(0, sa(0), 8'h00, "R3 falling ignored in rising mode");
    pins[0] = 1'b1;
    idle(4);
    wr(0, sa(0), 8'h00);
    chk(0, sa(0), 8'h01, "R6 write-zero has no effect");
    wr(0, sa(0), 8'h01);
    chk(0, sa(0), 8'h00, "R6 clear again");

    // R4 capture while masked, pin1 falling
    wr(0, ca(1), 8'd150);
    pins[1] = 1'b1;
    idle(4);
    chk(0, sa(1), 8'h00, "R3 rising ignored in falling mode");
    pins[1] = 1'b0;
    idle(4);
    chk(0, sa(1), 8'h01, "R4 status latched while masked");
    chk(1, 4'h0, 8'h00, "R5 masked pin gives no irq");
    wr(0, ca(1), 8'd151);
    chk(1, 4'h0, 8'h01, "R5 irq after enabling");
    wr(0, sa(1), 8'h01);
    chk(1, 4'h0, 8'h00, "R5 irq after clearing pin1");

    // R5 routing mismatch, R3 both edges on pin2
    wr(0, ca(2), 8'd95);
    pins[2] = 1'b1;
    idle(4);
    chk(0, sa(2), 8'h01, "R3 both-edge rising");
    chk(1, 4'h0, 8'h00, "R5 other route gives no irq");
    wr(0, sa(2), 8'h01);
    pins[2] = 1'b0;
    idle(4);
    chk(0, sa(2), 8'h01, "R3 both-edge falling");
    wr(0, sa(2), 8'h01);

    // R3 level modes and R7 level held through clear, pin3
    wr(0, ca(3), 8'd135);
    idle(3);
    chk(0, sa(3), 8'h00, "R3 level high inactive");
    pins[3] = 1'b1;
    idle(4);
    chk(0, sa(3), 8'h01, "R3 level high active");
    wr(0, sa(3), 8'h01);
    chk(0, sa(3), 8'h01, "R7 active level survives clear");
    pins[3] = 1'b0;
    idle(4);
    wr(0, sa(3), 8'h01);
    chk(0, sa(3), 8'h00, "R7 clear after level released");
    wr(0, ca(3), 8'd131);
    idle(2);
    chk(0, sa(3), 8'h01, "R3 level low active");
    pins[3] = 1'b1;
    idle(4);
    wr(0, sa(3), 8'h01);
    chk(0, sa(3), 8'h00, "R3 level low released");
    wr(0, ca(3), 8'd0);

    // R8 mode changes on a steady high pin4
    pins[4] = 1'b1;
    idle(4);
    wr(0, ca(4), 8'd143);
    idle(3);
    wr(0, ca(4), 8'd151);
    idle(3);
    wr(0, ca(4), 8'd159);
    idle(3);
    wr(0, ca(4), 8'd131);
    idle(3);
    chk(0, sa(4), 8'h00, "R8 mode changes set no status");

    // R4 capture disabled, pin5
    wr(0, ca(5), 8'd141);
    pins[5] = 1'b1;
    idle(4);
    chk(0, sa(5), 8'h00, "R4 no capture when disabled");
    chk(1, 4'h0, 8'h00, "R4 no irq when capture disabled");

    // R7 edge coinciding with clear, pin6 both edges
    wr(0, ca(6), 8'd159);
    pins[6] = 1'b1;
    idle(4);
    pins[6] = 1'b0;
    idle(2);
    wr(0, sa(6), 8'h01);
    chk(0, sa(6), 8'h01, "R7 edge wins over clear");
    wr(0, sa(6), 8'h01);
    chk(0, sa(6), 8'h00, "R7 later clear works");

    // R9 one-bit variant with write-zero acknowledge, pin7 on uut_n
    wr(1, ca(7), 8'd139);
    chk(2, ca(7), 8'd139, "R2 variant readback");
    pins[7] = 1'b1;
    idle(4);
    chk(2, sa(7), 8'h00, "R9 rising ignored with polarity 0");
    pins[7] = 1'b0;
    idle(4);
    chk(2, sa(7), 8'h01, "R9 falling edge caught");
    chk(3, 4'h0, 8'h01, "R5 variant irq");
    wr(1, sa(7), 8'h01);
    chk(2, sa(7), 8'h01, "R6 write-one no effect when ACK_HIGH=0");
    wr(1, sa(7), 8'h00);
    chk(2, sa(7), 8'h00, "R6 write-zero clears when ACK_HIGH=0");
    chk(3, 4'h0, 8'h00, "R5 variant irq dropped");
    wr(1, ca(7), 8'd143);
    pins[7] = 1'b1;
    idle(4);
    chk(2, sa(7), 8'h01, "R9 rising with polarity 1");
    wr(1, ca(7), 8'd135);
    wr(1, sa(7), 8'h00);
    chk(2, sa(7), 8'h01, "R9 level high held");
    pins[7] = 1'b0;
    idle(4);
    wr(1, sa(7), 8'h00);
    chk(2, sa(7), 8'h00, "R9 level released and cleared");

    idle(3);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule